// File: doc/BRIEF.md
# Drive Timing Register Bank with Mode Loader

This block holds the per-drive timing configuration of a two-drive disk channel. Software reaches every register through a pair of byte ports. It first writes a register number to the index port. It then reads or writes the selected register through the data port. The read data is combinational from the selected register.

Beside the software path, a mode loader watches for transfer-mode select events. Each event carries a drive number and a transfer-mode code. The loader decodes the code into a timing class (PIO, multiword DMA or Ultra DMA) and a mode number. It then overwrites that drive's timing registers with bytes taken from a per-mode table. The table in use depends on whether the channel clock belongs to the 133 MHz class or the 100 MHz class. A cable-sense input shows up in a read-only status register. When that input reports a 40-conductor cable, it also limits the Ultra DMA speed.

Top module: `tmg_regbank`

## Requirements
- R1: Writing the index port with `idx_we_i` stores the register number. A data-port write with `dat_we_i` then updates the selected register at the next rising clock edge. `dat_rdata_o` always shows the currently selected register.
- R2: Reset state:
  - the index is 0 and `mode_err_o` is 0;
  - indices 0x0c/0x0d/0x13, and the same indices plus 8, hold 0xfb/0x2b/0xac;
  - every other register reads 0.
- R3: Codes 0x08 to 0x0c select PIO modes 0 to 4. Such a code loads three bytes into drive-relative indices 0x0c, 0x0d and 0x13.
- R4: Codes 0x20 to 0x22 select multiword DMA modes 0 to 2. Such a code loads two bytes into indices 0x0c+2 and 0x0c+3, that is 0x0e and 0x0f.
- R5: Codes 0x40 to 0x46 select Ultra DMA modes 0 to 6. Such a code loads three bytes into indices 0x10, 0x11 and 0x12.
- R6: Drive 0 uses the base indices. Drive 1 uses the base indices plus 8. A load for one drive leaves the other drive's registers unchanged.
- R7: With `clk_fast_i`=1, the 133 MHz table is used. With `clk_fast_i`=0, the 100 MHz table is used. Examples from the fast table:
  - PIO 0 loads 0xfb/0x2b/0xac;
  - PIO 4 loads 0x23/0x09/0x25;
  - Ultra DMA 6 loads 0x1a/0x01/0xcb.
- R8: In the 100 MHz class, Ultra DMA mode 2 leaves bit 7 of index 0x10 (plus the drive offset) cleared. The bytes loaded are 0x22/0x06/0x9e.
- R9: Index 0x0b is read-only. It reads bit 2 = `cable40_i` and all other bits 0, and data-port writes to it have no effect. While `cable40_i`=1, Ultra DMA modes 3 to 6 load the mode 2 bytes.
- R10: A mode code outside R3 to R5 changes no register. It raises `mode_err_o` for exactly the cycle after the event.
- R11: A mode load overwrites values that software wrote earlier. When a load and a data-port write hit the same register in the same cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_we_i | input | 1 | Index port write strobe |
| idx_wdata_i | input | 8 | Register number to select |
| dat_we_i | input | 1 | Data port write strobe |
| dat_wdata_i | input | 8 | Data port write value |
| dat_rdata_o | output | 8 | Selected register contents |
| mode_set_i | input | 1 | Transfer-mode select event |
| mode_drive_i | input | 1 | Drive targeted by the event |
| mode_code_i | input | 8 | Transfer-mode code |
| clk_fast_i | input | 1 | 1 = 133 MHz clock class, 0 = 100 MHz |
| cable40_i | input | 1 | 1 = 40-conductor cable fitted |
| mode_err_o | output | 1 | One-cycle pulse for an unknown mode code |

## Verification
The hardest case to reach is a mode load and a software write that land on the same register in the same clock cycle. The stimulus first parks the index on a PIO timing register. It then raises the data strobe and the mode event on one falling edge, so both act at a single rising edge. The other difficult cases are the cable clamp and the slow-class hold-bit rule. These only show with specific combinations of the class, cable and code inputs, so the vector table lists those combinations explicitly and reads back every loaded register.

// File: rtl/tmg_pkg.sv
package tmg_pkg;
  typedef enum logic [1:0] {K_NONE, K_PIO, K_MW, K_UDMA} tmg_kind_e;

  localparam logic [7:0] IX_STATUS = 8'h0b;
  localparam logic [7:0] IX_BASE   = 8'h0c;
  localparam logic [7:0] IX_PIO_A  = 8'h0c;
  localparam logic [7:0] IX_PIO_B  = 8'h0d;
  localparam logic [7:0] IX_PIO_C  = 8'h13;
  localparam logic [7:0] IX_MW_A   = 8'h0e;
  localparam logic [7:0] IX_MW_B   = 8'h0f;
  localparam logic [7:0] IX_UD_A   = 8'h10;
  localparam logic [7:0] IX_UD_B   = 8'h11;
  localparam logic [7:0] IX_UD_C   = 8'h12;

  function automatic logic [23:0] pio_tab(input logic fast, input logic [2:0] m);
    case ({fast, m})
      4'b1_000: return 24'hfb2bac;
      4'b1_001: return 24'h4629a4;
      4'b1_010: return 24'h232664;
      4'b1_011: return 24'h270d35;
      4'b1_100: return 24'h230925;
      4'b0_000: return 24'hc422ac;
      4'b0_001: return 24'h3521a4;
      4'b0_010: return 24'h1b1e64;
      4'b0_011: return 24'h1e0a35;
      4'b0_100: return 24'h1b0725;
      default:  return 24'h0;
    endcase
  endfunction

  function automatic logic [15:0] mw_tab(input logic fast, input logic [2:0] m);
    case ({fast, m})
      4'b1_000: return 16'hdf5f;
      4'b1_001: return 16'h6b27;
      4'b1_010: return 16'h6925;
      4'b0_000: return 16'ha84a;
      4'b0_001: return 16'h521e;
      4'b0_010: return 16'h501c;
      default:  return 16'h0;
    endcase
  endfunction

  function automatic logic [23:0] udma_tab(input logic fast, input logic [2:0] m);
    case ({fast, m})
      4'b1_000: return 24'h4a0fd5;
      4'b1_001: return 24'h3a0ad0;
      4'b1_010: return 24'h2a07cd;
      4'b1_011: return 24'h1a05cd;
      4'b1_100: return 24'h1a03cd;
      4'b1_101: return 24'h1a02cb;
      4'b1_110: return 24'h1a01cb;
      4'b0_000: return 24'h390ca2;
      4'b0_001: return 24'h2d08a0;
      4'b0_010: return 24'ha2069e;
      4'b0_011: return 24'h15049e;
      4'b0_100: return 24'h15039e;
      4'b0_101: return 24'h15029c;
      4'b0_110: return 24'h15019c;
      default:  return 24'h0;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(input int unsigned i, input int unsigned step);
    if (i == IX_PIO_A || i == IX_PIO_A + step) return 8'hfb;
    if (i == IX_PIO_B || i == IX_PIO_B + step) return 8'h2b;
    if (i == IX_PIO_C || i == IX_PIO_C + step) return 8'hac;
    return 8'h00;
  endfunction
endpackage

// File: rtl/tmg_mode_dec.sv
module tmg_mode_dec
  import tmg_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int DRV_STEP = 8,
  parameter int LD_N     = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        set_i,
  input  logic                        drive_i,
  input  logic [7:0]                  code_i,
  input  logic                        fast_i,
  input  logic                        cable40_i,
  output logic [LD_N-1:0]             ld_en_o,
  output logic [LD_N-1:0][IDX_W-1:0]  ld_idx_o,
  output logic [LD_N-1:0][7:0]        ld_val_o,
  output logic                        bad_o
);
  localparam logic [IDX_W-1:0] OFF = IDX_W'(DRV_STEP);

  tmg_kind_e         kind;
  logic [2:0]        mode, umode;
  logic [IDX_W-1:0]  off;
  logic [23:0]       tri_v;
  logic [15:0]       duo_v;

  assign mode  = code_i[2:0];
  assign umode = (cable40_i && mode > 3'd2) ? 3'd2 : mode;
  assign off   = drive_i ? OFF : '0;

  always_comb begin
    case (code_i[7:3])
      5'h01:   kind = (mode <= 3'd4) ? K_PIO  : K_NONE;
      5'h04:   kind = (mode <= 3'd2) ? K_MW   : K_NONE;
      5'h08:   kind = (mode <= 3'd6) ? K_UDMA : K_NONE;
      default: kind = K_NONE;
    endcase
  end

  always_comb begin
    ld_en_o  = '0;
    ld_idx_o = '0;
    ld_val_o = '0;
    tri_v    = '0;
    duo_v    = '0;
    case (kind)
      K_PIO: begin
        tri_v    = pio_tab(fast_i, mode);
        ld_en_o  = {LD_N{set_i}};
        ld_idx_o = {IDX_W'(IX_PIO_C) + off, IDX_W'(IX_PIO_B) + off, IDX_W'(IX_PIO_A) + off};
        ld_val_o = {tri_v[7:0], tri_v[15:8], tri_v[23:16]};
      end
      K_MW: begin
        duo_v       = mw_tab(fast_i, mode);
        ld_en_o[0]  = set_i;
        ld_en_o[1]  = set_i;
        ld_idx_o[0] = IDX_W'(IX_MW_A) + off;
        ld_idx_o[1] = IDX_W'(IX_MW_B) + off;
        ld_val_o[0] = duo_v[15:8];
        ld_val_o[1] = duo_v[7:0];
      end
      K_UDMA: begin
        tri_v = udma_tab(fast_i, umode);
        if (!fast_i && umode == 3'd2) tri_v[23] = 1'b0;  // hold bit off in slow class
        ld_en_o  = {LD_N{set_i}};
        ld_idx_o = {IDX_W'(IX_UD_C) + off, IDX_W'(IX_UD_B) + off, IDX_W'(IX_UD_A) + off};
        ld_val_o = {tri_v[7:0], tri_v[15:8], tri_v[23:16]};
      end
      default: ;
    endcase
  end

  assign bad_o = set_i && (kind == K_NONE);

  for (genvar k = 0; k < LD_N; k++) begin : g_chk
    p_drive_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_en_o[k] |-> (ld_idx_o[k] >= IDX_W'(IX_BASE) + off) &&
                     (ld_idx_o[k] <  IDX_W'(IX_BASE) + off + OFF));
  end

  p_no_load_on_bad_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_o |-> ld_en_o == '0);
endmodule

// File: rtl/tmg_regfile.sv
module tmg_regfile
  import tmg_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int REG_N    = 32,
  parameter int DRV_STEP = 8,
  parameter int LD_N     = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sw_we_i,
  input  logic [IDX_W-1:0]            sw_idx_i,
  input  logic [7:0]                  sw_data_i,
  input  logic [LD_N-1:0]             ld_en_i,
  input  logic [LD_N-1:0][IDX_W-1:0]  ld_idx_i,
  input  logic [LD_N-1:0][7:0]        ld_val_i,
  output logic [REG_N-1:0][7:0]       regs_o
);
  for (genvar i = 0; i < REG_N; i++) begin : g_reg
    logic       hit;
    logic [7:0] nv;
    logic       sw_hit;

    always_comb begin
      hit = 1'b0;
      nv  = '0;
      for (int k = 0; k < LD_N; k++) begin
        if (ld_en_i[k] && ld_idx_i[k] == IDX_W'(i)) begin
          hit = 1'b1;
          nv  = ld_val_i[k];
        end
      end
    end

    assign sw_hit = sw_we_i && sw_idx_i == IDX_W'(i) && IDX_W'(i) != IDX_W'(IX_STATUS);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     regs_o[i] <= rst_val(i, DRV_STEP);
      else if (hit)    regs_o[i] <= nv;       // loader beats software
      else if (sw_hit) regs_o[i] <= sw_data_i;
    end

    p_idle_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit && !(sw_we_i && sw_idx_i == IDX_W'(i)) |=> $stable(regs_o[i]));
  end
endmodule

// File: rtl/tmg_regbank.sv
module tmg_regbank
  import tmg_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int REG_N    = 32,
  parameter int DRV_STEP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idx_we_i,
  input  logic [IDX_W-1:0] idx_wdata_i,
  input  logic             dat_we_i,
  input  logic [7:0]       dat_wdata_i,
  output logic [7:0]       dat_rdata_o,
  input  logic             mode_set_i,
  input  logic             mode_drive_i,
  input  logic [7:0]       mode_code_i,
  input  logic             clk_fast_i,
  input  logic             cable40_i,
  output logic             mode_err_o
);
  localparam int LD_N = 3;

  logic [IDX_W-1:0]            idx_q;
  logic [LD_N-1:0]             ld_en;
  logic [LD_N-1:0][IDX_W-1:0]  ld_idx;
  logic [LD_N-1:0][7:0]        ld_val;
  logic                        bad;
  logic [REG_N-1:0][7:0]       regs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= '0;
      mode_err_o <= 1'b0;
    end else begin
      if (idx_we_i) idx_q <= idx_wdata_i;
      mode_err_o <= bad;
    end
  end

  tmg_mode_dec #(.IDX_W(IDX_W), .DRV_STEP(DRV_STEP), .LD_N(LD_N)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (mode_set_i),
    .drive_i   (mode_drive_i),
    .code_i    (mode_code_i),
    .fast_i    (clk_fast_i),
    .cable40_i (cable40_i),
    .ld_en_o   (ld_en),
    .ld_idx_o  (ld_idx),
    .ld_val_o  (ld_val),
    .bad_o     (bad)
  );

  tmg_regfile #(.IDX_W(IDX_W), .REG_N(REG_N), .DRV_STEP(DRV_STEP), .LD_N(LD_N)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_we_i   (dat_we_i),
    .sw_idx_i  (idx_q),
    .sw_data_i (dat_wdata_i),
    .ld_en_i   (ld_en),
    .ld_idx_i  (ld_idx),
    .ld_val_i  (ld_val),
    .regs_o    (regs)
  );

  always_comb begin
    if (idx_q == IDX_W'(IX_STATUS))      dat_rdata_o = {5'b0, cable40_i, 2'b0};
    else if (idx_q < IDX_W'(REG_N))      dat_rdata_o = regs[idx_q[$clog2(REG_N)-1:0]];
    else                                 dat_rdata_o = 8'h00;
  end

  p_err_follows_event_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> $past(mode_set_i));

  p_slow_hold_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_set_i && !clk_fast_i && mode_code_i == 8'h42 && !mode_drive_i &&
    idx_q == IDX_W'(IX_UD_A) && !idx_we_i |=> !dat_rdata_o[7]);

  p_status_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q == IDX_W'(IX_STATUS) && !idx_we_i |=> dat_rdata_o[7:3] == 5'b0 && dat_rdata_o[1:0] == 2'b0);
endmodule

// File: tb/test_tmg_regbank.sv
module test_tmg_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idx_we = 0, dat_we = 0, mset = 0, mdrv = 0, fast = 1, cab = 0;
  logic [7:0] idx_wd = 0, dat_wd = 0, mcode = 0;
  logic [7:0] rdata;
  logic merr;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  tmg_regbank i_tmg_regbank (
    .clk_i(clk), .rst_ni(rst_n), .idx_we_i(idx_we), .idx_wdata_i(idx_wd),
    .dat_we_i(dat_we), .dat_wdata_i(dat_wd), .dat_rdata_o(rdata),
    .mode_set_i(mset), .mode_drive_i(mdrv), .mode_code_i(mcode),
    .clk_fast_i(fast), .cable40_i(cab), .mode_err_o(merr)
  );

  typedef struct packed {
    logic       drv, fst, cbl;
    logic [7:0] code;
    logic [1:0] n;
    logic [7:0] i0, v0, i1, v1, i2, v2;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,8'h0c,2'd3,8'h0c,8'h23,8'h0d,8'h09,8'h13,8'h25},  // R3 R7 PIO4 fast
    '{1'b1,1'b1,1'b0,8'h46,2'd3,8'h18,8'h1a,8'h19,8'h01,8'h1a,8'hcb},  // R5 R6 R7 UDMA6 d1
    '{1'b0,1'b1,1'b0,8'h21,2'd2,8'h0e,8'h6b,8'h0f,8'h27,8'h00,8'h00},  // R4 MW1
    '{1'b1,1'b1,1'b0,8'h08,2'd3,8'h14,8'hfb,8'h15,8'h2b,8'h1b,8'hac},  // R3 R6 PIO0 d1
    '{1'b0,1'b0,1'b0,8'h42,2'd3,8'h10,8'h22,8'h11,8'h06,8'h12,8'h9e},  // R8 slow UDMA2
    '{1'b1,1'b1,1'b1,8'h45,2'd3,8'h18,8'h2a,8'h19,8'h07,8'h1a,8'hcd},  // R9 clamp to UDMA2
    '{1'b0,1'b0,1'b0,8'h22,2'd2,8'h0e,8'h50,8'h0f,8'h1c,8'h00,8'h00},  // R4 R7 slow MW2
    '{1'b1,1'b0,1'b0,8'h42,2'd3,8'h18,8'h22,8'h19,8'h06,8'h1a,8'h9e},  // R8 R6 d1
    '{1'b0,1'b1,1'b0,8'h40,2'd3,8'h10,8'h4a,8'h11,8'h0f,8'h12,8'hd5}   // R5 UDMA0
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic sel(input logic [7:0] i);
    @(negedge clk); idx_we = 1; idx_wd = i;
    @(negedge clk); idx_we = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] i, input logic [7:0] exp);
    sel(i);
    check(tag, rdata, exp);
  endtask

  task automatic wr(input logic [7:0] i, input logic [7:0] d);
    sel(i);
    dat_we = 1; dat_wd = d;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic evt(input logic d, input logic [7:0] c);
    @(negedge clk); mset = 1; mdrv = d; mcode = c;
    @(negedge clk); mset = 0;
  endtask

  initial begin
    #50000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 index0", rdata, 8'h00);
    check("R2 err", {7'b0, merr}, 8'h00);
    rst_n = 1;
    rd("R2 pio_a d0", 8'h0c, 8'hfb);
    rd("R2 pio_c d1", 8'h1b, 8'hac);
    rd("R2 udma_a d0", 8'h10, 8'h00);

    // R1 software access
    wr(8'h05, 8'h5a);
    rd("R1 readback", 8'h05, 8'h5a);

    // table walk
    for (int v = 0; v < NV; v++) begin
      fast = VEC[v].fst; cab = VEC[v].cbl;
      evt(VEC[v].drv, VEC[v].code);
      rd($sformatf("R3/R4/R5 vec%0d a", v), VEC[v].i0, VEC[v].v0);
      rd($sformatf("R3/R4/R5 vec%0d b", v), VEC[v].i1, VEC[v].v1);
      if (VEC[v].n == 2'd3) rd($sformatf("R3/R5 vec%0d c", v), VEC[v].i2, VEC[v].v2);
    end
    fast = 1; cab = 0;

    // R6 other drive untouched: d0 PIO4 earlier, d1 PIO1 now
    evt(1'b1, 8'h09);
    rd("R6 d1 pio_a", 8'h14, 8'h46);
    rd("R6 d0 pio_a kept", 8'h0c, 8'h23);

    // R9 status read-only, cable bit 2
    wr(8'h0b, 8'hff);
    check("R9 status cable0", rdata, 8'h00);
    cab = 1;
    @(negedge clk);
    check("R9 status cable1", rdata, 8'h04);
    cab = 0;

    // R11 load overwrites software value
    wr(8'h13, 8'h27);
    rd("R11 sw set", 8'h13, 8'h27);
    evt(1'b0, 8'h0a);
    check("R11 reload", rdata, 8'h64);

    // R11 same-cycle collision on index 0x0c
    sel(8'h0c);
    @(negedge clk); dat_we = 1; dat_wd = 8'h55; mset = 1; mdrv = 0; mcode = 8'h09;
    @(negedge clk); dat_we = 0; mset = 0;
    check("R11 load wins", rdata, 8'h46);

    // R10 unknown code
    sel(8'h0c);
    @(negedge clk); mset = 1; mdrv = 0; mcode = 8'h0d;
    @(negedge clk); mset = 0;
    check("R10 err pulse", {7'b0, merr}, 8'h01);
    check("R10 reg kept", rdata, 8'h46);
    @(negedge clk);
    check("R10 err one cycle", {7'b0, merr}, 8'h00);
    evt(1'b0, 8'h47);
    check("R10 udma7 err", {7'b0, merr}, 8'h01);
    rd("R10 udma kept", 8'h10, 8'h4a);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule